// File: doc/BRIEF.md
# Interrupt and DMA Request Router

This block holds the pending-event state of a storage-card host controller and turns it into one level-sensitive interrupt line for the processor and two DMA request lines, one for receive and one for transmit. Thirteen event sources inside the controller raise request bits with single-cycle pulses. A request bit then stays set until software clears it. Software can clear it by writing a one to it in the request register, or the bit for a FIFO service request is cleared as a side effect of a receive FIFO read or a transmit FIFO write.

A 13-bit mask register suppresses individual sources. A control register carries a DMA-enable bit. While that bit is set, the two FIFO service requests (receive at bit 5, transmit at bit 6) are kept away from the processor interrupt whatever the mask holds, and they drive the DMA request lines instead. While it is clear, both DMA lines stay low.

All three outputs are registered. Software reads the request, mask and control registers through a combinational read port.

Top module: `rir_irq_dma_router`

## Requirements
- R1: After reset the request, mask and control registers read zero, and the interrupt and both DMA request lines are low.
- R2: A pulse on `evt_set_i[n]` sets request bit n at the next clock edge. The bit then stays set until one of the clear actions of R3 or R4 removes it.
- R3: A write with `wr_sel_i`=1 clears every request bit whose data bit is 1 and leaves every other request bit unchanged.
- R4: `rx_pop_i` clears request bit 5 (receive FIFO service) and `tx_push_i` clears request bit 6 (transmit FIFO service). No other bit is affected.
- R5: When a set event and any clear action reach the same request bit in the same cycle, the bit ends up set.
- R6: A write with `wr_sel_i`=0 loads the mask from data bits 12:0. Bits 15:13 of the mask read back as zero.
- R7: The interrupt line is high when some request bit is set and its mask bit is clear. While DMA mode is on, bits 5 and 6 count as masked.
- R8: While DMA mode is on, the receive DMA line equals request bit 5 and the transmit DMA line equals request bit 6. While DMA mode is off, both lines are low.
- R9: A write with `wr_sel_i`=2 sets DMA mode from data bit 7. A control read (`rd_sel_i`=2) returns only that bit, at position 7, and zero elsewhere. Select value 3 writes nothing and reads zero.
- R10: The interrupt and DMA lines follow the register state one clock later. A state change made at edge k shows on the outputs after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_set_i | input | 13 | Per-source set pulses from the controller |
| rx_pop_i | input | 1 | Receive FIFO read strobe, clears bit 5 |
| tx_push_i | input | 1 | Transmit FIFO write strobe, clears bit 6 |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 mask, 1 request (write-one-to-clear), 2 control, 3 none |
| wr_data_i | input | 16 | Write data |
| rd_sel_i | input | 2 | Read target, same encoding as wr_sel_i |
| rd_data_o | output | 16 | Read data, combinational |
| irq_o | output | 1 | Level interrupt to the processor |
| dma_rx_req_o | output | 1 | Receive DMA request |
| dma_tx_req_o | output | 1 | Transmit DMA request |

## Verification
Directed cases come first. They isolate a lone set pulse and show that it holds, and they exercise the two ways a clear happens: a one-to-clear write that touches only some bits, and a FIFO strobe. A set and a clear on the same bit in one cycle shows that set wins, and a full-width mask write shows that the upper bits are dropped.

A DMA sequence sets only bits 5 and 6 with the mask open. The interrupt has to fall and the DMA lines have to rise, which separates the forced masking from the mask register. The one-edge output lag is sampled explicitly.

Thousands of random cycles then mix sparse set pulses, strobes, and writes to random targets. A bench model predicts all three lines and all three read values every cycle. These cycles catch interactions between the mask, DMA mode and clear priority that the directed cases leave out.

// File: rtl/rir_pkg.sv
package rir_pkg;

    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,
        SEL_REQ  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } rir_sel_e;

    localparam int RIR_NSRC    = 13;
    localparam int RIR_RX_IDX  = 5;
    localparam int RIR_TX_IDX  = 6;
    localparam int RIR_DMA_POS = 7;
    localparam int RIR_DW      = 16;

endpackage

// File: rtl/rir_req_bank.sv
module rir_req_bank #(
    parameter int NSRC   = 13,
    parameter int RX_IDX = 5,
    parameter int TX_IDX = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] w1c_i,
    input  logic            rx_pop_i,
    input  logic            tx_push_i,
    output logic [NSRC-1:0] req_o
);

    typedef struct packed {
        logic [NSRC-1:0] req;
    } bank_t;

    bank_t           st_d, st_q;
    logic [NSRC-1:0] clr_vec;

    always_comb begin
        clr_vec = w1c_i;
        clr_vec[RX_IDX] = clr_vec[RX_IDX] | rx_pop_i;
        clr_vec[TX_IDX] = clr_vec[TX_IDX] | tx_push_i;
        st_d     = st_q;
        // set is applied after clear so that it wins on a collision
        st_d.req = (st_q.req & ~clr_vec) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o = st_q.req;

    // R5: a set pulse always leaves its bit set
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((st_q.req & $past(set_i)) == $past(set_i)));

    // R2: a bit only drops when a clear reached it
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.req != '0) |=> ((~st_q.req & $past(st_q.req) & ~$past(clr_vec)) == '0));

endmodule

// File: rtl/rir_route.sv
module rir_route #(
    parameter int NSRC   = 13,
    parameter int RX_IDX = 5,
    parameter int TX_IDX = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_i,
    input  logic [NSRC-1:0] mask_i,
    input  logic            dma_en_i,
    output logic            irq_o,
    output logic            dma_rx_o,
    output logic            dma_tx_o
);

    typedef struct packed {
        logic irq;
        logic rx;
        logic tx;
    } out_t;

    out_t            o_d, o_q;
    logic [NSRC-1:0] fifo_bits;
    logic [NSRC-1:0] eff_mask;

    always_comb begin
        fifo_bits         = '0;
        fifo_bits[RX_IDX] = 1'b1;
        fifo_bits[TX_IDX] = 1'b1;
        eff_mask = mask_i | (dma_en_i ? fifo_bits : '0);
        o_d.irq  = |(req_i & ~eff_mask);
        o_d.rx   = dma_en_i & req_i[RX_IDX];
        o_d.tx   = dma_en_i & req_i[TX_IDX];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign irq_o    = o_q.irq;
    assign dma_rx_o = o_q.rx;
    assign dma_tx_o = o_q.tx;

    // R8: DMA lines stay low while DMA mode was off
    a_r8_dma_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en_i |=> (!dma_rx_o && !dma_tx_o));

    // R7: no pending request means no interrupt one edge later
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == '0) |=> !irq_o);

    // R7: in DMA mode, FIFO requests alone never raise the interrupt
    a_r7_dma_hides_fifo: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en_i && ((req_i & ~mask_i & ~fifo_bits) == '0)) |=> !irq_o);

endmodule

// File: rtl/rir_irq_dma_router.sv
module rir_irq_dma_router
    import rir_pkg::*;
#(
    parameter int NSRC    = RIR_NSRC,
    parameter int DW      = RIR_DW,
    parameter int RX_IDX  = RIR_RX_IDX,
    parameter int TX_IDX  = RIR_TX_IDX,
    parameter int DMA_POS = RIR_DMA_POS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_set_i,
    input  logic            rx_pop_i,
    input  logic            tx_push_i,
    input  logic            wr_en_i,
    input  logic [1:0]      wr_sel_i,
    input  logic [DW-1:0]   wr_data_i,
    input  logic [1:0]      rd_sel_i,
    output logic [DW-1:0]   rd_data_o,
    output logic            irq_o,
    output logic            dma_rx_req_o,
    output logic            dma_tx_req_o
);

    localparam int PAD = DW - NSRC;

    typedef struct packed {
        logic [NSRC-1:0] mask;
        logic            dma_en;
    } cfg_t;

    cfg_t            cfg_d, cfg_q;
    logic [NSRC-1:0] w1c;
    logic [NSRC-1:0] req;
    rir_sel_e        wsel, rsel;
    logic            unused_hi;

    assign wsel      = rir_sel_e'(wr_sel_i);
    assign rsel      = rir_sel_e'(rd_sel_i);
    assign unused_hi = ^wr_data_i[DW-1:NSRC];

    always_comb begin
        cfg_d = cfg_q;
        w1c   = '0;
        if (wr_en_i) begin
            case (wsel)
                SEL_MASK: cfg_d.mask   = wr_data_i[NSRC-1:0];
                SEL_REQ:  w1c          = wr_data_i[NSRC-1:0];
                SEL_CTRL: cfg_d.dma_en = wr_data_i[DMA_POS];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rd_data_o = '0;
        case (rsel)
            SEL_MASK: rd_data_o = {{PAD{1'b0}}, cfg_q.mask};
            SEL_REQ:  rd_data_o = {{PAD{1'b0}}, req};
            SEL_CTRL: rd_data_o[DMA_POS] = cfg_q.dma_en;
            default:  rd_data_o = '0;
        endcase
    end

    rir_req_bank #(.NSRC(NSRC), .RX_IDX(RX_IDX), .TX_IDX(TX_IDX)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (evt_set_i),
        .w1c_i     (w1c),
        .rx_pop_i  (rx_pop_i),
        .tx_push_i (tx_push_i),
        .req_o     (req)
    );

    rir_route #(.NSRC(NSRC), .RX_IDX(RX_IDX), .TX_IDX(TX_IDX)) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req),
        .mask_i   (cfg_q.mask),
        .dma_en_i (cfg_q.dma_en),
        .irq_o    (irq_o),
        .dma_rx_o (dma_rx_req_o),
        .dma_tx_o (dma_tx_req_o)
    );

    // R9: control writes touch only DMA mode, never the mask
    a_r9_ctrl_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wsel == SEL_CTRL) |=> $stable(cfg_q.mask));

endmodule

// File: tb/rir_irq_dma_router_bench.sv
module rir_irq_dma_router_bench;

    localparam int N = 13;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  evt_set;
    logic          rx_pop, tx_push, wr_en;
    logic [1:0]    wr_sel, rd_sel;
    logic [15:0]   wr_data, rd_data;
    logic          irq, dma_rx, dma_tx;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [N-1:0] m_req, m_mask;
    logic         m_dma, e_irq, e_rx, e_tx;

    always #10 clk = ~clk;

    rir_irq_dma_router u_rir_irq_dma_router (
        .clk(clk), .rst_n(rst_n), .evt_set_i(evt_set), .rx_pop_i(rx_pop),
        .tx_push_i(tx_push), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
        .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
        .irq_o(irq), .dma_rx_req_o(dma_rx), .dma_tx_req_o(dma_tx)
    );

    function automatic logic f_irq(logic [N-1:0] r, logic [N-1:0] m, logic d);
        logic [N-1:0] em;
        em = m;
        if (d) begin em[5] = 1'b1; em[6] = 1'b1; end
        return |(r & ~em);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        evt_set = '0; rx_pop = 0; tx_push = 0; wr_en = 0;
        wr_sel = 2'd3; wr_data = '0; rd_sel = 2'd1;
    endtask

    // one clock: drive at negedge, update model after edge, check at next negedge
    task automatic cycle(logic [N-1:0] s, logic rp, logic tp, logic we,
                         logic [1:0] ws, logic [15:0] wd);
        logic [N-1:0] clr;
        evt_set = s; rx_pop = rp; tx_push = tp; wr_en = we; wr_sel = ws; wr_data = wd;
        @(posedge clk);
        #1;
        e_irq = f_irq(m_req, m_mask, m_dma);       // R10: outputs lag state by one edge
        e_rx  = m_dma & m_req[5];
        e_tx  = m_dma & m_req[6];
        clr = '0;
        if (we && ws == 2'd1) clr = wd[N-1:0];
        clr[5] = clr[5] | rp;
        clr[6] = clr[6] | tp;
        m_req = (m_req & ~clr) | s;                 // R5: set wins
        if (we && ws == 2'd0) m_mask = wd[N-1:0];
        if (we && ws == 2'd2) m_dma  = wd[7];
        idle_inputs();
        @(negedge clk);
        chk("R7 irq", irq, e_irq);
        chk("R8 dma_rx", dma_rx, e_rx);
        chk("R8 dma_tx", dma_tx, e_tx);
        rd_sel = 2'd1; #1 chk("R2 request read", rd_data, {3'b0, m_req});
        rd_sel = 2'd0; #1 chk("R6 mask read", rd_data, {3'b0, m_mask});
        rd_sel = 2'd2; #1 chk("R9 ctrl read", rd_data, {8'b0, m_dma, 7'b0});
        rd_sel = 2'd3; #1 chk("R9 none read", rd_data, 16'h0);
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        idle_inputs();
        rst_n = 0;
        m_req = '0; m_mask = '0; m_dma = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 dma", {dma_rx, dma_tx}, 0);
        rd_sel = 2'd1; #1 chk("R1 req", rd_data, 0);
        rd_sel = 2'd0; #1 chk("R1 mask", rd_data, 0);
        rd_sel = 2'd2; #1 chk("R1 ctrl", rd_data, 0);

        // R10 lag: set bit 2, interrupt still low on the first negedge
        cycle(13'h0004, 0, 0, 0, 2'd3, 0);
        chk("R10 irq lags state", irq, 0);
        cycle('0, 0, 0, 0, 2'd3, 0);
        chk("R2 bit held, irq up", {rd_data[2], irq}, 2'b01);  // rd_sel=3 reads 0
        rd_sel = 2'd1; #1 chk("R2 bit 2 held", rd_data[2], 1);

        // R3 partial write-one-to-clear
        cycle(13'h1105, 0, 0, 0, 2'd3, 0);
        cycle('0, 0, 0, 1, 2'd1, 16'h0101);
        rd_sel = 2'd1; #1 chk("R3 w1c partial", rd_data, 16'h1004);

        // R4 FIFO strobes
        cycle(13'h0060, 0, 0, 0, 2'd3, 0);
        cycle('0, 1, 0, 0, 2'd3, 0);
        rd_sel = 2'd1; #1 chk("R4 rx pop clears bit5", rd_data, 16'h1044);
        cycle('0, 0, 1, 0, 2'd3, 0);
        rd_sel = 2'd1; #1 chk("R4 tx push clears bit6", rd_data, 16'h1004);

        // R5 set and clear together
        cycle(13'h0020, 1, 0, 1, 2'd1, 16'h0020);
        rd_sel = 2'd1; #1 chk("R5 set beats clear", rd_data[5], 1);

        // R6 mask width
        cycle('0, 0, 0, 1, 2'd0, 16'hFFFF);
        rd_sel = 2'd0; #1 chk("R6 mask upper bits drop", rd_data, 16'h1FFF);
        cycle('0, 0, 0, 0, 2'd3, 0);
        chk("R7 fully masked irq low", irq, 0);

        // R8 DMA mode: only FIFO bits pending, mask open
        cycle('0, 0, 0, 1, 2'd1, 16'h1FFF);
        cycle(13'h0060, 0, 0, 1, 2'd0, 16'h0000);
        cycle('0, 0, 0, 1, 2'd2, 16'h0080);
        cycle('0, 0, 0, 0, 2'd3, 0);
        chk("R8 dma lines up", {dma_rx, dma_tx}, 2'b11);
        chk("R7 dma hides fifo irq", irq, 0);
        cycle('0, 0, 0, 1, 2'd2, 16'hFF7F);
        cycle('0, 0, 0, 0, 2'd3, 0);
        chk("R8 dma off lines low", {dma_rx, dma_tx}, 2'b00);
        chk("R7 fifo irq back", irq, 1);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [N-1:0] s;
            logic [15:0]  d;
            s = N'($urandom & $urandom & $urandom);
            d = 16'($urandom);
            cycle(s, ($urandom % 4) == 0, ($urandom % 4) == 0,
                  ($urandom % 3) == 0, 2'($urandom), d);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule